// File: doc/BRIEF.md
# Trigger-Gated Sample Valid Generator

A free-running converter hands over one sample word on every clock cycle, whatever the sensor front end is doing. Most of those words carry no pixel data. This block decides which words are real. It takes the front end's "outputs driven" strobe and runs it through a delay line of fixed depth. The depth equals the conversion and capture latency, so the delayed strobe lines up with the sample words it describes. It then marks those words with stream valid and last flags. The last flag is set on the final word of each readout burst.

A slow macro-pulse trigger opens a gate that passes a programmed number of whole readouts and then closes again. Outside that window the samples still flow through the block, but no valid flag is raised. The gate opens only at the start of a burst, so a readout is never cut short at its front. A trigger that arrives while a block is being counted is ignored. Two status outputs report whether the gate is in use and how many readouts the current block has delivered.

Top module: `trig_valid_gen`

## Requirements
- R1: `m_tdata` is `sample_in` registered once. A cycle with `fe_active` high, if it is passed, shows up as `m_tvalid` high exactly DEPTH+1 cycles later, carrying the sample that was presented DEPTH cycles after that strobe cycle.
- R2: `m_tlast` is high only together with `m_tvalid`. It marks the word whose strobe cycle is followed by a cycle with `fe_active` low.
- R3: After reset, `m_tvalid`, `m_tlast` and `busy` are low and `frames_done` is 0. No word is marked valid until a trigger has been accepted.
- R4: A rising edge of `macro_trig` while the gate is idle and `frame_budget` is non-zero arms the gate. The first burst whose first word reaches the output after arming is passed whole, and so is every following burst, until exactly `frame_budget` bursts have been passed. Later bursts are suppressed.
- R5: A rising edge of `macro_trig` while `busy` is high has no effect on the count or on which bursts are passed.
- R6: If the trigger is accepted while the delayed strobe is in the middle of a burst, none of that burst is emitted. Passing starts with the next burst.
- R7: The budget is captured when the trigger is accepted. Changing `frame_budget` later does not alter the current block.
- R8: A trigger with `frame_budget` equal to 0 is ignored, and `busy` stays low.
- R9: The budget is a CW-bit count (16 bits by default). A block of 10000 readouts is delivered in full.
- R10: `busy` is high from the cycle after acceptance. It drops in the same cycle that the last word of the final burst is presented. `frames_done` is cleared on acceptance, rises by one in each cycle that shows `m_tlast`, and otherwise holds.
- R11: One-word bursts, and bursts separated by a single idle strobe cycle, are each treated as a complete readout, with their own `m_tlast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_active | input | 1 | Front end is driving its outputs (undelayed) |
| sample_in | input | DW | Converter sample word, present on every cycle |
| macro_trig | input | 1 | Slow macro-pulse trigger, rising edge active |
| frame_budget | input | CW | Number of readouts to pass per trigger |
| m_tdata | output | DW | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Last word of a readout burst |
| busy | output | 1 | Gate armed or passing |
| frames_done | output | CW | Readouts emitted in the current block |

## Verification
The checker assumes that `fe_active` comes from a sequencer that holds it high for whole readouts and low for at least one cycle between them. It also assumes that the sample words are already aligned to the delayed strobe. Under those assumptions, the flags and the counter can relate to each other only in the ways the checker states. The bench drives the strobe only in whole bursts with gaps of one or more idle cycles. It raises the trigger at chosen cycles: in the idle gap, inside a delayed burst, and during a running block. Whether each burst is expected to pass is decided from that placement alone.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,
    GATE_ARMED = 2'd1,
    GATE_RUN   = 2'd2
  } gate_state_t;
endpackage

// File: rtl/tvg_strobe_delay.sv
// Fixed-depth delay line for the front-end strobe. Gives the aligned tap and
// the tap one stage earlier, which tells whether the next word is active.
module tvg_strobe_delay #(
  parameter int DEPTH = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic cur,
  output logic nxt
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= strobe_in;
      end
      assign nxt = strobe_in;
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], strobe_in};
      end
      assign nxt = sr[DEPTH-2];
    end
  endgenerate

  assign cur = sr[DEPTH-1];
endmodule

// File: rtl/tvg_edge_detect.sv
module tvg_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/tvg_burst_gate.sv
// Per-macro-pulse gate: arms on a trigger, opens on a burst start and closes
// after the captured number of complete bursts.
module tvg_burst_gate
  import tvg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cur,
  input  logic          nxt,
  input  logic          trig_rise,
  input  logic [CW-1:0] budget,
  output logic          pass,
  output logic          word_last,
  output logic          busy,
  output logic [CW-1:0] count
);
  gate_state_t   st;
  logic [CW-1:0] bud_q;
  logic          cur_q;
  logic          burst_start;
  logic          final_burst;

  assign burst_start = cur & ~cur_q;
  assign word_last   = cur & ~nxt;
  assign pass        = cur & ((st == GATE_RUN) | ((st == GATE_ARMED) & burst_start));
  assign final_burst = ((count + 1'b1) == bud_q);
  assign busy        = (st != GATE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= GATE_IDLE;
      bud_q <= '0;
      count <= '0;
      cur_q <= 1'b0;
    end else begin
      cur_q <= cur;
      case (st)
        GATE_IDLE: begin
          if (trig_rise && (budget != '0)) begin
            st    <= GATE_ARMED;
            bud_q <= budget;
            count <= '0;
          end
        end
        GATE_ARMED, GATE_RUN: begin
          if (pass) begin
            if (word_last) begin
              count <= count + 1'b1;
              st    <= final_burst ? GATE_IDLE : GATE_RUN;
            end else begin
              st <= GATE_RUN;
            end
          end
        end
        default: st <= GATE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_valid_gen.sv
module trig_valid_gen #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fe_active,
  input  logic [DW-1:0] sample_in,
  input  logic          macro_trig,
  input  logic [CW-1:0] frame_budget,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  output logic          busy,
  output logic [CW-1:0] frames_done
);
  logic cur, nxt, trig_rise, pass, word_last;

  tvg_strobe_delay #(.DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst(rst), .strobe_in(fe_active), .cur(cur), .nxt(nxt)
  );

  tvg_edge_detect u_trig (
    .clk(clk), .rst(rst), .level_in(macro_trig), .rise(trig_rise)
  );

  tvg_burst_gate #(.CW(CW)) u_gate (
    .clk(clk), .rst(rst), .cur(cur), .nxt(nxt), .trig_rise(trig_rise),
    .budget(frame_budget), .pass(pass), .word_last(word_last),
    .busy(busy), .count(frames_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else begin
      m_tdata  <= sample_in;
      m_tvalid <= pass;
      m_tlast  <= pass & word_last;
    end
  end
endmodule

// File: rtl/tvg_chk.sv
module tvg_chk #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] sample_in,
  input logic [DW-1:0] m_tdata,
  input logic          m_tvalid,
  input logic          m_tlast,
  input logic          busy,
  input logic [CW-1:0] frames_done
);
  // R2
  tlast_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> m_tvalid);

  // R1
  tdata_align_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tdata == $past(sample_in)));

  // R4
  valid_gated_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (busy || m_tlast));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> ((frames_done - $past(frames_done)) == CW'(1)));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> m_tlast);

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!m_tlast && (frames_done != $past(frames_done))) |-> (frames_done == '0));
endmodule

bind trig_valid_gen tvg_chk #(.DW(DW), .CW(CW)) u_tvg_chk (
  .clk(clk), .rst(rst), .sample_in(sample_in), .m_tdata(m_tdata),
  .m_tvalid(m_tvalid), .m_tlast(m_tlast), .busy(busy),
  .frames_done(frames_done)
);

// File: tb/trig_valid_gen_test.sv
module trig_valid_gen_test;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int D  = 15;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          l;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fe_active = 1'b0;
  logic          macro_trig = 1'b0;
  logic [CW-1:0] frame_budget = '0;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid, m_tlast, busy;
  logic [CW-1:0] frames_done;
  logic [31:0]   cyc = 0;
  int            checks = 0;
  int            errors = 0;
  item_t         expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_valid_gen #(.DW(DW), .CW(CW), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .fe_active(fe_active), .sample_in(cyc[DW-1:0]),
    .macro_trig(macro_trig), .frame_budget(frame_budget), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast), .busy(busy),
    .frames_done(frames_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares every emitted word against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (m_tlast && !m_tvalid) chk(1'b0, "R2 tlast without tvalid", 1, 0);
      if (m_tvalid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3/R4 unexpected valid word", int'(m_tdata), -1);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(m_tdata == e.d, "R1 data alignment", int'(m_tdata), int'(e.d));
          chk(m_tlast == e.l, "R2/R11 tlast position", int'(m_tlast), int'(e.l));
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fe_active = 1'b0;
      macro_trig = 1'b0;
    end
  endtask

  task automatic burst(input int len, input bit pass, input int trig_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fe_active = 1'b1;
      macro_trig = (i == trig_at);
      if (pass) expq.push_back({DW'(cyc + D), (i == len - 1)});
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    macro_trig = 1'b1;
    @(negedge clk);
    macro_trig = 1'b0;
  endtask

  task automatic drained(input string tag);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk(!m_tvalid && !m_tlast, "R3 reset flags", int'(m_tvalid), 0);
    chk(!busy, "R3 reset busy", int'(busy), 0);
    chk(frames_done == 0, "R3 reset count", int'(frames_done), 0);

    // R3 nothing passes before a trigger
    burst(8, 0, -1); idle(3); burst(8, 0, -1); idle(30);
    drained("R3 suppressed before trigger");

    // R4, R5, R7: block of three
    frame_budget = 3;
    pulse_trig(); idle(5);
    chk(busy, "R10 busy after accept", int'(busy), 1);
    chk(frames_done == 0, "R10 count cleared", int'(frames_done), 0);
    burst(8, 1, -1); idle(25);
    chk(frames_done == 1, "R10 count after one", int'(frames_done), 1);
    frame_budget = 1;                      // R7 change mid-block
    pulse_trig();                          // R5 trigger while busy
    idle(25);
    burst(8, 1, -1); idle(25);
    chk(frames_done == 2, "R5 count not restarted", int'(frames_done), 2);
    burst(8, 1, -1); idle(25);
    chk(frames_done == 3, "R7 full budget kept", int'(frames_done), 3);
    chk(!busy, "R4 gate closed", int'(busy), 0);
    burst(8, 0, -1); idle(25);
    drained("R4 exact burst count");

    // R6 trigger inside a delayed burst
    frame_budget = 1;
    idle(25);
    burst(20, 0, D + 2); idle(25);
    chk(busy && frames_done == 0, "R6 armed, partial burst dropped", int'(frames_done), 0);
    burst(5, 1, -1); idle(25);
    chk(frames_done == 1 && !busy, "R6 next burst whole", int'(frames_done), 1);
    drained("R6 no partial words");

    // R8 zero budget
    frame_budget = 0;
    pulse_trig(); idle(5);
    chk(!busy, "R8 zero budget ignored", int'(busy), 0);
    chk(frames_done == 1, "R8 count held", int'(frames_done), 1);
    burst(6, 0, -1); idle(25);
    drained("R8 no words");

    // R11 short bursts, single-cycle gaps
    frame_budget = 4;
    pulse_trig(); idle(25);
    burst(1, 1, -1); idle(1); burst(1, 1, -1); idle(1);
    burst(3, 1, -1); idle(1); burst(2, 1, -1); idle(1);
    burst(2, 0, -1); idle(25);
    chk(frames_done == 4 && !busy, "R11 short bursts counted", int'(frames_done), 4);
    drained("R11 queue");

    // 256-word readouts
    frame_budget = 2;
    pulse_trig(); idle(25);
    burst(256, 1, -1); idle(10); burst(256, 1, -1); idle(25);
    chk(frames_done == 2, "R4 full readouts", int'(frames_done), 2);
    drained("R4 full readouts queue");

    // R9 large budget
    frame_budget = 10000;
    pulse_trig(); idle(25);
    for (int k = 0; k < 10000; k++) begin
      burst(2, 1, -1); idle(1);
    end
    burst(2, 0, -1); idle(25);
    chk(frames_done == 10000, "R9 large block count", int'(frames_done), 10000);
    chk(!busy, "R9 gate closed", int'(busy), 0);
    drained("R9 queue");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule